// File: doc/BRIEF.md
# Ethernet PHY LED Behaviour Controller

This block decides, every clock, whether each LED pin of a 10/100/1000 Ethernet PHY is lit. It watches the PHY's state (link and speed, power-down, energy-efficient mode, auto-negotiation, analog self-test, cable diagnostics, test mode) and the transmit, receive and collision activity strobes. Each LED has two 8-bit configuration registers. They choose a condition that lights the LED steadily, a condition that makes it blink fast, a condition that makes it blink slowly, and a mask of activity events that fire a fixed-length flash.

Two global registers hold the fast and slow blink rates and three 3-bit chip-wide triggers. The triggers override every per-LED setting: a running light across the LEDs, its inverse, and all LEDs blinking together. A free-running prescaler divides a reference tick into blink steps. A small write port and a combinational read port reach the registers, which come out of reset with fixed defaults.

Top module: `phy_led_ctrl`

## Requirements
- R1: After reset the read port returns 0x00C5 at address 0 (global high), 0x0067 at address 1 (global low), and for LED n the high register at address 2+2n and the low register at 3+2n, with the values 0x70/0x03, 0x20/0x00, 0x40/0x00 and 0x40/0x20 for LEDs 0 to 3. Bits 15:8 and the unused global bits (high bit 3, low bits 7 and 3) always read as zero.
- R2: A write takes effect on the next clock edge. In global high, bits 7:6 are the fast rate, bits 5:4 the slow rate and bits 2:0 the inverse-scan trigger. In global low, bits 6:4 are the scan trigger and bits 2:0 the group-blink trigger. A per-LED register stores bits 7:0. Writes to unmapped addresses change nothing, and unmapped addresses read as zero.
- R3: A 4-bit condition code is true as follows. 0 is never true. Codes 1 to 7 are true when the link is up and its speed is in the set whose bit 0 = 10, bit 1 = 100 and bit 2 = 1000 Mbit/s (speed input 0 = 10, 1 = 100, 2 = 1000, 3 = none). 8 = power-down, 9 = EEE, 10 = auto-negotiation, 11 = analog self-test, 12 = cable diagnostics, and 13 to 15 are never true. The high register's bits 7:4 select the steady-on condition.
- R4: Without a global trigger, an LED is resolved by priority: an active flash lights it; otherwise, if its fast condition (high bits 3:0) holds, it follows the fast wave; otherwise, if its slow condition (low bits 7:4) holds, it follows the slow wave; otherwise it shows its steady-on condition.
- R5: Low register bits 3:0 form an event mask: bit 0 = transmit, bit 1 = receive, bit 2 = collision, and bit 3 has no effect. While no flash is running, an allowed event starts a flash lasting PULSE_LEN cycles. Events during a flash do not extend it, so continuous traffic gives PULSE_LEN cycles on and one cycle off.
- R6: Every TICK_DIV reference ticks the prescaler takes one step. A wave with rate code r (0 = 2 Hz, 1 = 4 Hz, 2 = 8 Hz, 3 = 16 Hz) is a 50% square wave that changes only on steps and holds each level for 2^(3-r) steps.
- R7: A rate change is applied at the next prescaler step, and the waves never change between steps.
- R8: A 3-bit trigger is true as follows: 0 = never, 1 = link up, 2 = power-down, 3 = EEE, 4 = auto-negotiation, 5 = analog self-test, 6 = cable diagnostics, 7 = test mode.
- R9: While the scan trigger is true, exactly one LED is lit: the one at the scan position. The scan position advances by one on every prescaler step and wraps after the last LED.
- R10: While the inverse-scan trigger is true (and scan is not), every LED except the one at the scan position is lit.
- R11: While the group-blink trigger is true (and neither scan mode is), every LED follows the fast wave.
- R12: The global triggers rank scan, then inverse scan, then group blink, all above the per-LED settings.
- R13: The LED outputs are registered: the result for the inputs and state of one cycle appears after the following clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_tick | input | 1 | Reference tick that feeds the blink prescaler |
| link_up | input | 1 | Link is up |
| link_speed | input | 2 | 0 = 10, 1 = 100, 2 = 1000 Mbit/s, 3 = none |
| pdown | input | 1 | PHY powered down |
| eee_mode | input | 1 | Energy-efficient mode active |
| aneg_busy | input | 1 | Auto-negotiation running |
| abist_busy | input | 1 | Analog self-test running |
| cdiag_busy | input | 1 | Cable diagnostics running |
| test_mode | input | 1 | Test mode active |
| tx_act | input | 1 | Transmit activity strobe |
| rx_act | input | 1 | Receive activity strobe |
| col_evt | input | 1 | Collision strobe |
| wr_en | input | 1 | Register write enable |
| wr_addr | input | ADDR_W | Register write address |
| wr_data | input | 16 | Register write data |
| rd_addr | input | ADDR_W | Register read address |
| rd_data | output | 16 | Read data (combinational) |
| led_o | output | NUM_LEDS | LED on/off outputs |

## Verification
The bench builds the block with four LEDs, TICK_DIV = 2 and PULSE_LEN = 3. One prescaler step then takes two cycles, so even the 2 Hz wave completes a period in 32 cycles, and a full scan round and every rate change fit within a few dozen cycles. The short flash lets the no-retrigger on/off rhythm under continuous traffic be counted exactly. The reference tick is also gated in one phase, so prescaler steps are taken only on ticks.

// File: rtl/phy_led_pkg.sv
package phy_led_pkg;

  localparam logic [1:0] SPD_10   = 2'd0;
  localparam logic [1:0] SPD_100  = 2'd1;
  localparam logic [1:0] SPD_1000 = 2'd2;

  typedef struct packed {
    logic       link_up;
    logic [1:0] speed;
    logic       pdown;
    logic       eee;
    logic       aneg;
    logic       abist;
    logic       cdiag;
    logic       test;
  } phy_stat_t;

  // 4-bit per-LED condition selector
  function automatic logic sel_hit(input logic [3:0] code, input phy_stat_t st);
    logic [2:0] spd_oh;
    logic       hit;
    case (st.speed)
      SPD_10:   spd_oh = 3'b001;
      SPD_100:  spd_oh = 3'b010;
      SPD_1000: spd_oh = 3'b100;
      default:  spd_oh = 3'b000;
    endcase
    if (!code[3]) begin
      hit = st.link_up && (|(code[2:0] & spd_oh));
    end else begin
      case (code[2:0])
        3'd0:    hit = st.pdown;
        3'd1:    hit = st.eee;
        3'd2:    hit = st.aneg;
        3'd3:    hit = st.abist;
        3'd4:    hit = st.cdiag;
        default: hit = 1'b0;
      endcase
    end
    return hit;
  endfunction

  // 3-bit global trigger selector
  function automatic logic trig_hit(input logic [2:0] code, input phy_stat_t st);
    logic hit;
    case (code)
      3'd1:    hit = st.link_up;
      3'd2:    hit = st.pdown;
      3'd3:    hit = st.eee;
      3'd4:    hit = st.aneg;
      3'd5:    hit = st.abist;
      3'd6:    hit = st.cdiag;
      3'd7:    hit = st.test;
      default: hit = 1'b0;
    endcase
    return hit;
  endfunction

  function automatic logic [7:0] led_hi_rst(input int idx);
    case (idx)
      0:       return 8'h70;
      1:       return 8'h20;
      2:       return 8'h40;
      3:       return 8'h40;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] led_lo_rst(input int idx);
    case (idx)
      0:       return 8'h03;
      3:       return 8'h20;
      default: return 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/phy_led_regs.sv
module phy_led_regs
  import phy_led_pkg::*;
#(
  parameter int NUM_LEDS = 4,
  parameter int ADDR_W   = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [ADDR_W-1:0]        wr_addr,
  input  logic [15:0]              wr_data,
  input  logic [ADDR_W-1:0]        rd_addr,
  output logic [15:0]              rd_data,
  output logic [1:0]               fast_rate,
  output logic [1:0]               slow_rate,
  output logic [2:0]               inv_code,
  output logic [2:0]               scan_code,
  output logic [2:0]               grp_code,
  output logic [NUM_LEDS-1:0][7:0] led_hi,
  output logic [NUM_LEDS-1:0][7:0] led_lo
);

  logic glb_hi_we;
  logic glb_lo_we;

  assign glb_hi_we = wr_en && (wr_addr == ADDR_W'(0));
  assign glb_lo_we = wr_en && (wr_addr == ADDR_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fast_rate <= 2'd3;
      slow_rate <= 2'd0;
      inv_code  <= 3'd5;
    end else if (glb_hi_we) begin
      fast_rate <= wr_data[7:6];
      slow_rate <= wr_data[5:4];
      inv_code  <= wr_data[2:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scan_code <= 3'd6;
      grp_code  <= 3'd7;
    end else if (glb_lo_we) begin
      scan_code <= wr_data[6:4];
      grp_code  <= wr_data[2:0];
    end
  end

  for (genvar i = 0; i < NUM_LEDS; i++) begin : g_led_reg
    logic hi_we;
    logic lo_we;
    assign hi_we = wr_en && (wr_addr == ADDR_W'(2 + 2 * i));
    assign lo_we = wr_en && (wr_addr == ADDR_W'(3 + 2 * i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        led_hi[i] <= led_hi_rst(i);
      end else if (hi_we) begin
        led_hi[i] <= wr_data[7:0];
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        led_lo[i] <= led_lo_rst(i);
      end else if (lo_we) begin
        led_lo[i] <= wr_data[7:0];
      end
    end
  end

  always_comb begin
    rd_data = 16'h0000;
    if (rd_addr == ADDR_W'(0)) begin
      rd_data = {8'h00, fast_rate, slow_rate, 1'b0, inv_code};
    end else if (rd_addr == ADDR_W'(1)) begin
      rd_data = {8'h00, 1'b0, scan_code, 1'b0, grp_code};
    end
    for (int i = 0; i < NUM_LEDS; i++) begin
      if (rd_addr == ADDR_W'(2 + 2 * i)) rd_data = {8'h00, led_hi[i]};
      if (rd_addr == ADDR_W'(3 + 2 * i)) rd_data = {8'h00, led_lo[i]};
    end
  end

  AST_GLB_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    glb_hi_we |=> (fast_rate == $past(wr_data[7:6]) && inv_code == $past(wr_data[2:0]))); // R2

endmodule

// File: rtl/phy_led_blink.sv
module phy_led_blink #(
  parameter int NUM_LEDS = 4,
  parameter int TICK_DIV = 2,
  parameter int SCAN_W   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ref_tick,
  input  logic [1:0]        fast_rate,
  input  logic [1:0]        slow_rate,
  output logic              fast_wave,
  output logic              slow_wave,
  output logic [SCAN_W-1:0] scan_pos
);

  localparam int DIV_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;

  logic [DIV_W-1:0]  div_cnt, div_nxt;
  logic [3:0]        phase, phase_nxt;
  logic              step;
  logic              fast_nxt, slow_nxt;
  logic [SCAN_W-1:0] scan_nxt;

  always_comb begin
    step      = ref_tick && (div_cnt == DIV_W'(TICK_DIV - 1));
    div_nxt   = step ? '0 : div_cnt + DIV_W'(1);
    phase_nxt = phase + 4'd1;
    // rate code r picks phase bit 3-r, i.e. the bitwise inverse of r
    fast_nxt  = phase_nxt[~fast_rate];
    slow_nxt  = phase_nxt[~slow_rate];
    scan_nxt  = (scan_pos == SCAN_W'(NUM_LEDS - 1)) ? '0 : scan_pos + SCAN_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_cnt <= '0;
    end else if (ref_tick) begin
      div_cnt <= div_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase     <= 4'd0;
      fast_wave <= 1'b0;
      slow_wave <= 1'b0;
      scan_pos  <= '0;
    end else if (step) begin
      phase     <= phase_nxt;
      fast_wave <= fast_nxt;
      slow_wave <= slow_nxt;
      scan_pos  <= scan_nxt;
    end
  end

  AST_WAVE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> ($stable(fast_wave) && $stable(slow_wave))); // R7

  AST_SCAN_MOVES: assert property (@(posedge clk) disable iff (!rst_n)
    (step && NUM_LEDS > 1) |=> (scan_pos != $past(scan_pos))); // R9

endmodule

// File: rtl/phy_led_pulse.sv
module phy_led_pulse #(
  parameter int PULSE_LEN = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] mask_i,
  input  logic [2:0] act_i,
  output logic       pulse_o
);

  localparam int CNT_W = $clog2(PULSE_LEN + 1);

  logic [CNT_W-1:0] cnt, cnt_nxt;
  logic             hit;
  logic             cnt_en;

  always_comb begin
    hit    = |(mask_i & act_i);
    cnt_en = (cnt != '0) || hit;
    if (cnt != '0) begin
      cnt_nxt = cnt - CNT_W'(1);
    end else begin
      cnt_nxt = CNT_W'(PULSE_LEN);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (cnt_en) begin
      cnt <= cnt_nxt;
    end
  end

  assign pulse_o = (cnt != '0);

  AST_PULSE_START: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == '0 && hit) |=> (cnt == CNT_W'(PULSE_LEN))); // R5

  AST_PULSE_NO_RETRIG: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt != '0) |=> (cnt == $past(cnt) - CNT_W'(1))); // R5

endmodule

// File: rtl/phy_led_ctrl.sv
module phy_led_ctrl
  import phy_led_pkg::*;
#(
  parameter int NUM_LEDS  = 4,
  parameter int TICK_DIV  = 31250,
  parameter int PULSE_LEN = 3750000,
  localparam int ADDR_W   = $clog2(2 * NUM_LEDS + 2),
  localparam int SCAN_W   = (NUM_LEDS > 1) ? $clog2(NUM_LEDS) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ref_tick,
  input  logic                link_up,
  input  logic [1:0]          link_speed,
  input  logic                pdown,
  input  logic                eee_mode,
  input  logic                aneg_busy,
  input  logic                abist_busy,
  input  logic                cdiag_busy,
  input  logic                test_mode,
  input  logic                tx_act,
  input  logic                rx_act,
  input  logic                col_evt,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic [15:0]         wr_data,
  input  logic [ADDR_W-1:0]   rd_addr,
  output logic [15:0]         rd_data,
  output logic [NUM_LEDS-1:0] led_o
);

  phy_stat_t               stat;
  logic [1:0]              fast_rate, slow_rate;
  logic [2:0]              inv_code, scan_code, grp_code;
  logic [NUM_LEDS-1:0][7:0] led_hi, led_lo;
  logic                    fast_wave, slow_wave;
  logic [SCAN_W-1:0]       scan_pos;
  logic [2:0]              act_vec;
  logic                    scan_act, inv_act, grp_act;
  logic [NUM_LEDS-1:0]     pulse_on;
  logic [NUM_LEDS-1:0]     led_nxt;

  always_comb begin
    stat.link_up = link_up;
    stat.speed   = link_speed;
    stat.pdown   = pdown;
    stat.eee     = eee_mode;
    stat.aneg    = aneg_busy;
    stat.abist   = abist_busy;
    stat.cdiag   = cdiag_busy;
    stat.test    = test_mode;
  end

  assign act_vec  = {col_evt, rx_act, tx_act};
  assign scan_act = trig_hit(scan_code, stat);
  assign inv_act  = trig_hit(inv_code, stat);
  assign grp_act  = trig_hit(grp_code, stat);

  phy_led_regs #(
    .NUM_LEDS (NUM_LEDS),
    .ADDR_W   (ADDR_W)
  ) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .rd_addr   (rd_addr),
    .rd_data   (rd_data),
    .fast_rate (fast_rate),
    .slow_rate (slow_rate),
    .inv_code  (inv_code),
    .scan_code (scan_code),
    .grp_code  (grp_code),
    .led_hi    (led_hi),
    .led_lo    (led_lo)
  );

  phy_led_blink #(
    .NUM_LEDS (NUM_LEDS),
    .TICK_DIV (TICK_DIV),
    .SCAN_W   (SCAN_W)
  ) u_blink (
    .clk       (clk),
    .rst_n     (rst_n),
    .ref_tick  (ref_tick),
    .fast_rate (fast_rate),
    .slow_rate (slow_rate),
    .fast_wave (fast_wave),
    .slow_wave (slow_wave),
    .scan_pos  (scan_pos)
  );

  for (genvar i = 0; i < NUM_LEDS; i++) begin : g_led
    logic on_hit, fast_hit, slow_hit, at_pos;

    phy_led_pulse #(
      .PULSE_LEN (PULSE_LEN)
    ) u_pulse (
      .clk     (clk),
      .rst_n   (rst_n),
      .mask_i  (led_lo[i][2:0]),
      .act_i   (act_vec),
      .pulse_o (pulse_on[i])
    );

    assign on_hit   = sel_hit(led_hi[i][7:4], stat);
    assign fast_hit = sel_hit(led_hi[i][3:0], stat);
    assign slow_hit = sel_hit(led_lo[i][7:4], stat);
    assign at_pos   = (scan_pos == SCAN_W'(i));

    always_comb begin
      if (scan_act)          led_nxt[i] = at_pos;
      else if (inv_act)      led_nxt[i] = !at_pos;
      else if (grp_act)      led_nxt[i] = fast_wave;
      else if (pulse_on[i])  led_nxt[i] = 1'b1;
      else if (fast_hit)     led_nxt[i] = fast_wave;
      else if (slow_hit)     led_nxt[i] = slow_wave;
      else                   led_nxt[i] = on_hit;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      led_o <= '0;
    end else begin
      led_o <= led_nxt;
    end
  end

  AST_SCAN_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    scan_act |=> ($countones(led_o) == 1)); // R9

  AST_INV_SCAN: assert property (@(posedge clk) disable iff (!rst_n)
    (!scan_act && inv_act) |=> ($countones(led_o) == NUM_LEDS - 1)); // R10

  AST_GROUP_BLINK: assert property (@(posedge clk) disable iff (!rst_n)
    (!scan_act && !inv_act && grp_act) |=> ((&led_o) || !(|led_o))); // R11

  AST_PULSE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (!scan_act && !inv_act && !grp_act && pulse_on[0]) |=> led_o[0]); // R4

endmodule

// File: tb/phy_led_ctrl_tb.sv
module phy_led_ctrl_tb;

  localparam int NL   = 4;
  localparam int DIV  = 2;
  localparam int PLEN = 3;
  localparam int AW   = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ref_tick = 1'b1;
  logic link_up = 1'b0;
  logic [1:0] link_speed = 2'd3;
  logic pdown = 0, eee_mode = 0, aneg_busy = 0, abist_busy = 0, cdiag_busy = 0, test_mode = 0;
  logic tx_act = 0, rx_act = 0, col_evt = 0;
  logic wr_en = 0;
  logic [AW-1:0] wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [AW-1:0] rd_addr = '0;
  logic [15:0] rd_data;
  logic [NL-1:0] led_o;

  always #10 clk = ~clk;

  phy_led_ctrl #(.NUM_LEDS(NL), .TICK_DIV(DIV), .PULSE_LEN(PLEN)) u_dut (
    .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .link_up(link_up),
    .link_speed(link_speed), .pdown(pdown), .eee_mode(eee_mode),
    .aneg_busy(aneg_busy), .abist_busy(abist_busy), .cdiag_busy(cdiag_busy),
    .test_mode(test_mode), .tx_act(tx_act), .rx_act(rx_act), .col_evt(col_evt),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
    .rd_data(rd_data), .led_o(led_o));

  int n_chk = 0;
  int n_err = 0;
  string cur_req = "R13";

  // ---------------- reference model ----------------
  int m_hi[NL], m_lo[NL], m_pc[NL];
  int m_fr, m_sr, m_inv, m_scan, m_grp;
  int m_div, m_ph, m_fw, m_sw, m_pos;
  logic [NL-1:0] m_led;

  function automatic bit m_sel(int code);
    int spd_bit;
    spd_bit = (link_speed == 2'd3) ? 0 : (1 << link_speed);
    if (code >= 1 && code <= 7) return link_up && ((code & spd_bit) != 0);
    case (code)
      8: return pdown;
      9: return eee_mode;
      10: return aneg_busy;
      11: return abist_busy;
      12: return cdiag_busy;
      default: return 0;
    endcase
  endfunction

  function automatic bit m_trig(int code);
    case (code)
      1: return link_up;
      2: return pdown;
      3: return eee_mode;
      4: return aneg_busy;
      5: return abist_busy;
      6: return cdiag_busy;
      7: return test_mode;
      default: return 0;
    endcase
  endfunction

  task automatic m_reset();
    m_hi[0] = 'h70; m_lo[0] = 'h03;
    m_hi[1] = 'h20; m_lo[1] = 'h00;
    m_hi[2] = 'h40; m_lo[2] = 'h00;
    m_hi[3] = 'h40; m_lo[3] = 'h20;
    m_fr = 3; m_sr = 0; m_inv = 5; m_scan = 6; m_grp = 7;
    m_div = 0; m_ph = 0; m_fw = 0; m_sw = 0; m_pos = 0;
    for (int i = 0; i < NL; i++) m_pc[i] = 0;
    m_led = '0;
  endtask

  task automatic m_step();
    bit sa, ia, ga, stp, ev;
    logic [NL-1:0] nl;
    sa = m_trig(m_scan); ia = m_trig(m_inv); ga = m_trig(m_grp);
    for (int i = 0; i < NL; i++) begin
      if (sa) nl[i] = (i == m_pos);
      else if (ia) nl[i] = (i != m_pos);
      else if (ga) nl[i] = m_fw[0];
      else if (m_pc[i] > 0) nl[i] = 1'b1;
      else if (m_sel(m_hi[i] & 15)) nl[i] = m_fw[0];
      else if (m_sel((m_lo[i] >> 4) & 15)) nl[i] = m_sw[0];
      else nl[i] = m_sel((m_hi[i] >> 4) & 15);
    end
    stp = ref_tick && (m_div == DIV - 1);
    if (ref_tick) m_div = stp ? 0 : m_div + 1;
    if (stp) begin
      m_ph = (m_ph + 1) % 16;
      m_fw = (m_ph >> (3 - m_fr)) & 1;
      m_sw = (m_ph >> (3 - m_sr)) & 1;
      m_pos = (m_pos + 1) % NL;
    end
    for (int i = 0; i < NL; i++) begin
      ev = ((m_lo[i] & 1) && tx_act) || ((m_lo[i] & 2) && rx_act) || ((m_lo[i] & 4) && col_evt);
      if (m_pc[i] > 0) m_pc[i] = m_pc[i] - 1;
      else if (ev) m_pc[i] = PLEN;
    end
    if (wr_en) begin
      if (wr_addr == 0) begin
        m_fr = (wr_data >> 6) & 3; m_sr = (wr_data >> 4) & 3; m_inv = wr_data & 7;
      end else if (wr_addr == 1) begin
        m_scan = (wr_data >> 4) & 7; m_grp = wr_data & 7;
      end else if (wr_addr >= 2 && wr_addr < 2 + 2 * NL) begin
        if (wr_addr[0] == 1'b0) m_hi[(wr_addr - 2) / 2] = wr_data & 'hFF;
        else m_lo[(wr_addr - 3) / 2] = wr_data & 'hFF;
      end
    end
    m_led = nl;
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) m_reset();
    else m_step();
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      n_chk++;
      if (led_o !== m_led) begin
        n_err++;
        $display("FAIL %s led_o=%b expected %b at %0t", cur_req, led_o, m_led, $time);
      end
    end
  end

  // ---------------- helpers ----------------
  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = AW'(a); wr_data = 16'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_chk(input string req, input int a, input int exp);
    @(negedge clk);
    rd_addr = AW'(a);
    #1;
    check(req, int'(rd_data), exp);
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clr_stat();
    @(negedge clk);
    link_up = 0; link_speed = 2'd3; pdown = 0; eee_mode = 0; aneg_busy = 0;
    abist_busy = 0; cdiag_busy = 0; test_mode = 0; tx_act = 0; rx_act = 0; col_evt = 0;
  endtask

  task automatic set_stat(input int k);
    clr_stat();
    case (k)
      0, 1, 2, 3: begin link_up = 1; link_speed = 2'(k); end
      4: pdown = 1;
      5: eee_mode = 1;
      6: aneg_busy = 1;
      7: abist_busy = 1;
      8: cdiag_busy = 1;
      default: test_mode = 1;
    endcase
  endtask

  task automatic count_rises(input int bitn, input int win, output int rises);
    logic prev;
    rises = 0;
    @(negedge clk);
    prev = led_o[bitn];
    for (int c = 0; c < win; c++) begin
      @(negedge clk);
      if (led_o[bitn] && !prev) rises++;
      prev = led_o[bitn];
    end
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int r, hi_cnt;
    cyc(3);
    rst_n = 1'b1;
    cyc(2);

    // R1 reset values
    cur_req = "R1";
    check("R1 led_o after reset", int'(led_o), 0);
    rd_chk("R1 glb hi", 0, 'h00C5);
    rd_chk("R1 glb lo", 1, 'h0067);
    rd_chk("R1 led0 hi", 2, 'h70);
    rd_chk("R1 led0 lo", 3, 'h03);
    rd_chk("R1 led1 hi", 4, 'h20);
    rd_chk("R1 led1 lo", 5, 'h00);
    rd_chk("R1 led2 hi", 6, 'h40);
    rd_chk("R1 led2 lo", 7, 'h00);
    rd_chk("R1 led3 hi", 8, 'h40);
    rd_chk("R1 led3 lo", 9, 'h20);

    // R2 writes, reserved bits, unmapped address
    cur_req = "R2";
    wr(0, 'hFFFF);
    rd_chk("R2 glb hi reserved bits", 0, 'h00F7);
    wr(1, 'hFFFF);
    rd_chk("R2 glb lo reserved bits", 1, 'h0077);
    wr(5, 'hA5C3);
    rd_chk("R2 led1 lo upper byte dropped", 5, 'hC3);
    wr(12, 'h00FF);
    rd_chk("R2 unmapped reads zero", 12, 0);
    rd_chk("R2 unmapped write leaves glb hi", 0, 'h00F7);
    rd_chk("R2 unmapped write leaves led1 lo", 5, 'hC3);
    wr(0, 'h00C0);   // fast 16 Hz, slow 2 Hz, no inverse scan
    wr(1, 'h0000);   // no scan, no group blink
    for (int i = 0; i < NL; i++) begin
      wr(2 + 2 * i, 0);
      wr(3 + 2 * i, 0);
    end
    cyc(2);
    check("R2 all sources off", int'(led_o), 0);

    // R3 steady-on codes across all status patterns
    cur_req = "R3";
    for (int code = 0; code < 16; code++) begin
      wr(2, code << 4);
      for (int k = 0; k < 10; k++) begin
        set_stat(k);
        cyc(2);
      end
    end
    set_stat(1);   // link at 100
    wr(2, 'h60);
    cyc(2);
    check("R3 code 6 at 100 Mbit/s", int'(led_o[0]), 1);
    wr(2, 'h50);
    cyc(2);
    check("R3 code 5 at 100 Mbit/s", int'(led_o[0]), 0);
    wr(2, 'hD0);
    set_stat(8);
    cyc(2);
    check("R3 code 13 never lit", int'(led_o[0]), 0);
    wr(2, 0);

    // R5 flash
    cur_req = "R5";
    clr_stat();
    wr(5, 'h01);
    @(negedge clk); tx_act = 1;
    @(negedge clk); tx_act = 0;
    hi_cnt = 0;
    for (int c = 0; c < 10; c++) begin
      @(negedge clk);
      if (led_o[1]) hi_cnt++;
    end
    check("R5 single strobe flash length", hi_cnt, PLEN);
    @(negedge clk); tx_act = 1;
    cyc(2);
    hi_cnt = 0;
    for (int c = 0; c < 16; c++) begin
      @(negedge clk);
      if (led_o[1]) hi_cnt++;
    end
    check("R5 continuous traffic on-cycles", hi_cnt, 12);
    tx_act = 0;
    cyc(6);
    wr(5, 'h08);
    @(negedge clk); tx_act = 1; rx_act = 1; col_evt = 1;
    hi_cnt = 0;
    for (int c = 0; c < 8; c++) begin
      @(negedge clk);
      if (led_o[1]) hi_cnt++;
    end
    check("R5 mask bit 3 has no effect", hi_cnt, 0);
    wr(5, 'h06);   // receive and collision
    cyc(12);
    clr_stat();
    wr(5, 0);
    cyc(6);

    // R4 priority
    cur_req = "R4";
    wr(6, 'h77);
    wr(7, 'h71);
    wr(0, 'h0C0);
    @(negedge clk); link_up = 1; link_speed = 2'd2;
    cyc(40);
    wr(6, 'h70);   // slow and steady only
    cyc(40);
    wr(7, 'h01);   // steady only, with pulse mask
    cyc(6);
    check("R4 steady when only steady holds", int'(led_o[2]), 1);
    @(negedge clk); tx_act = 1;
    cyc(20);
    clr_stat();
    wr(6, 0); wr(7, 0);

    // R6 blink rates
    cur_req = "R6";
    wr(8, 'h07);
    @(negedge clk); link_up = 1; link_speed = 2'd0;
    wr(0, 'hC0);
    cyc(40);
    count_rises(3, 64, r);
    check("R6 16 Hz rises per 64 cycles", r, 16);
    wr(0, 'h00);
    cyc(40);
    count_rises(3, 64, r);
    check("R6 2 Hz rises per 64 cycles", r, 2);
    wr(8, 'h00); wr(9, 'h70);   // slow blink
    for (int rt = 0; rt < 4; rt++) begin
      wr(0, rt << 4);
      cyc(40);
    end
    // gated reference tick
    for (int c = 0; c < 60; c++) begin
      @(negedge clk); ref_tick = (c % 3 == 0);
    end
    @(negedge clk); ref_tick = 1;

    // R7 rate change mid-run
    cur_req = "R7";
    wr(9, 0); wr(8, 'h07);
    wr(0, 'h00);
    cyc(7);
    wr(0, 'h80);
    cyc(9);
    wr(0, 'h40);
    cyc(30);
    clr_stat();
    wr(8, 0);

    // R8 trigger codes via scan
    cur_req = "R8";
    for (int code = 1; code < 8; code++) begin
      wr(1, code << 4);
      for (int k = 0; k < 10; k++) begin
        set_stat(k);
        cyc(3);
      end
    end
    clr_stat();

    // R9 scan
    cur_req = "R9";
    wr(1, 'h10);
    @(negedge clk); link_up = 1; link_speed = 2'd1;
    cyc(3);
    check("R9 scan one LED lit", $countones(led_o), 1);
    cyc(20);

    // R10 inverse scan
    cur_req = "R10";
    wr(1, 'h00);
    wr(0, 'hC1);
    cyc(3);
    check("R10 all but one lit", $countones(led_o), NL - 1);
    cyc(20);

    // R11 group blink
    cur_req = "R11";
    wr(0, 'hC0);
    wr(1, 'h01);
    cyc(3);
    check("R11 all LEDs equal", int'((&led_o) || !(|led_o)), 1);
    cyc(20);

    // R12 precedence among triggers
    cur_req = "R12";
    wr(0, 'hC1);
    wr(1, 'h11);
    cyc(3);
    check("R12 scan wins over others", $countones(led_o), 1);
    wr(1, 'h01);
    cyc(3);
    check("R12 inverse wins over group blink", $countones(led_o), NL - 1);
    wr(2, 'h70); wr(3, 'h01);
    @(negedge clk); tx_act = 1;
    wr(0, 'hC0); wr(1, 'h00);
    cyc(20);
    clr_stat();

    // R13 registered output: one cycle latency
    cur_req = "R13";
    wr(2, 'h10); wr(3, 0);
    @(negedge clk); link_up = 1; link_speed = 2'd0;
    #1;
    check("R13 not yet visible", int'(led_o[0]), 0);
    @(negedge clk);
    check("R13 visible after one edge", int'(led_o[0]), 1);
    cyc(4);
    finish_run();
  end

endmodule